// File: doc/BRIEF.md
# Serial Converter Host Frame Controller

This block is the host-side master for a serial 8-bit successive-approximation converter. Each accepted request runs one frame. The block drops chip select and sends a start bit and a channel assignment word on the serial data line, paced by a serial clock. The serial clock comes from the system clock through a programmable divider.

After the assignment word the controller releases the data line, so data in and data out can share one bidirectional wire. It ignores the settling slot. It then captures the conversion result twice: once most-significant bit first, and once as the trailing copy in the opposite order. It raises chip select, pulses `done` and reports the code. A `mismatch` flag is set when the two copies disagree.

A request is taken only while the block is idle. It carries:
- a 3-bit channel number;
- the input mode (single-ended or differential);
- a variant flag that selects the 4-channel or the 8-channel converter;
- the serial clock half period, counted in system clocks.

Top module: `sconv_host`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the outputs are idle: `cs_n`=1, `sclk`=0, `di_oe`=0, `lsb_en_n`=1, `done`=0, `busy`=0.
- R2: When `req_valid` is high while idle, the request is accepted at that clock edge. In the next cycle `cs_n`=0, `sclk`=0, `di_oe`=1 and `di_out`=1, which is the start bit.
- R3: The header is sent one bit per serial clock period, in this order: start bit 1, then `~req_diff` (1 means single-ended), then `req_chan[0]`. For the 4-channel variant (`req_wide`=0) the last bit is `req_chan[1]`. For the 8-channel variant (`req_wide`=1) the last two bits are `req_chan[2]` and then `req_chan[1]`. The header length H is therefore 4 or 5.
- R4: `sclk` starts low and spends exactly L system clocks in each phase. L is the latched `req_half`, and a value of 0 counts as 1. While `cs_n` is high, `sclk` stays low.
- R5: `di_out` changes only together with a falling `sclk` edge or at frame start. `di_oe` goes low with the falling edge that follows the H-th rising edge, and it stays low until the next frame.
- R6: The bit sampled on rising edge H+1 is the settling slot and is discarded. Rising edges H+2 to H+9 carry result bits 7 down to 0, and `result` reports them.
- R7: `lsb_en_n` goes low with the falling edge that follows rising edge H+9. It stays low until `cs_n` rises and is high at all other times.
- R8: Rising edges H+10 to H+16 carry result bits 1 to 7. `mismatch`=1 exactly when any of these differs from the matching bit of `result`, and `result` is reported either way.
- R9: A frame has exactly H+16 rising `sclk` edges. At the falling edge after the last one, `cs_n` returns high. `done` is high for one cycle in that same cycle, with `result` and `mismatch` valid.
- R10: A request made while `busy` is high is ignored. The running frame and its result are unaffected.
- R11: A request may be accepted in the `done` cycle. `cs_n` is then high for exactly one cycle, which gives the new frame a fresh falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a frame (taken only while idle) |
| req_chan | input | 3 | Channel number |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| req_wide | input | 1 | 1 = 8-channel variant, 0 = 4-channel variant |
| req_half | input | DIV_W | Serial clock half period in system clocks |
| busy | output | 1 | Frame in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| di_out | output | 1 | Serial data toward the converter |
| di_oe | output | 1 | Drive enable for `di_out` on a shared wire |
| lsb_en_n | output | 1 | Reverse-order output enable, active low |
| do_in | input | 1 | Serial data from the converter |
| done | output | 1 | One-cycle frame completion pulse |
| result | output | DATA_W | Captured conversion code |
| mismatch | output | 1 | The two result copies disagree |

## Verification
The bench drives the converter data line with a deliberate 1 in the settling slot. A controller that is off by one edge would shift that bit into `result` and drop bit 0.

Frames use both variants, a half period of 0 and half periods of several clocks. A wrong header length or a wrong select-bit order therefore shows up as a `di_out` miscompare, and a divider error as an `sclk` miscompare in a specific cycle.

Some frames corrupt one bit of the reverse-order copy. A design that compared the wrong bits would miss the flag, or would raise it on clean frames.

Requests are also made mid-frame and in the `done` cycle. A design that re-armed while busy would restart the frame, and one that could not chain frames would lose the back-to-back request.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

  localparam int HDR_MAX = 5;

  typedef struct packed {
    logic [2:0] chan;
    logic       diff;
    logic       wide;
  } sconv_req_t;

  // header bits in transmit order, index 0 first
  function automatic logic [HDR_MAX-1:0] hdr_bits(sconv_req_t r);
    logic [HDR_MAX-1:0] h;
    h[0] = 1'b1;
    h[1] = ~r.diff;
    h[2] = r.chan[0];
    h[3] = r.wide ? r.chan[2] : r.chan[1];
    h[4] = r.wide ? r.chan[1] : 1'b0;
    return h;
  endfunction

  function automatic logic [2:0] hdr_len(logic wide);
    return wide ? 3'd5 : 3'd4;
  endfunction

endpackage

// File: rtl/sconv_tick.sv
module sconv_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  always_comb begin
    if (half_len == '0) last = '0;
    else                last = half_len - 1'b1;
  end

  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sconv_hdr.sv
module sconv_hdr
  import sconv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  sconv_req_t       cfg,
  input  logic [CNT_W-1:0] idx,
  output logic             bit_o,
  output logic [2:0]       len
);
  logic [HDR_MAX-1:0] h;

  assign h   = hdr_bits(cfg);
  assign len = hdr_len(cfg.wide);

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < HDR_MAX; i++) begin
      if (idx == CNT_W'(i)) bit_o = h[i];
    end
  end
endmodule

// File: rtl/sconv_capture.sv
module sconv_capture #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [CNT_W-1:0]  idx,
  input  logic [2:0]        hlen,
  input  logic              do_in,
  output logic [DATA_W-1:0] fwd_word,
  output logic [DATA_W-2:0] rev_word
);
  logic [CNT_W-1:0] fwd_lo, fwd_hi, rev_lo, rev_hi;
  logic             in_fwd, in_rev;

  // idx is the zero-based number of the rising edge being taken
  always_comb begin
    fwd_lo = CNT_W'(hlen) + CNT_W'(1);
    fwd_hi = CNT_W'(hlen) + CNT_W'(DATA_W);
    rev_lo = CNT_W'(hlen) + CNT_W'(DATA_W + 1);
    rev_hi = CNT_W'(hlen) + CNT_W'(2 * DATA_W - 1);
    in_fwd = (idx >= fwd_lo) && (idx <= fwd_hi);
    in_rev = (idx >= rev_lo) && (idx <= rev_hi);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fwd_word <= '0;
      rev_word <= '0;
    end else if (sample) begin
      if (in_fwd) fwd_word <= {fwd_word[DATA_W-2:0], do_in};
      if (in_rev) rev_word <= {do_in, rev_word[DATA_W-2:1]};
    end
  end
endmodule

// File: rtl/sconv_host.sv
module sconv_host
  import sconv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_chan,
  input  logic              req_diff,
  input  logic              req_wide,
  input  logic [DIV_W-1:0]  req_half,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              di_out,
  output logic              di_oe,
  output logic              lsb_en_n,
  input  logic              do_in,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              mismatch
);
  localparam int EDGE_MAX = HDR_MAX + 2 * DATA_W;
  localparam int CNT_W    = $clog2(EDGE_MAX + 1);

  sconv_req_t        cfg;
  logic [DIV_W-1:0]  half_q;
  logic [CNT_W-1:0]  rise_cnt;
  logic              run;
  logic              tick;
  logic              hdr_bit;
  logic [2:0]        hlen;
  logic [CNT_W-1:0]  frame_len, lsb_from;
  logic              in_hdr;
  logic              start;
  logic [DATA_W-1:0] fwd_word;
  logic [DATA_W-2:0] rev_word;

  assign start     = !run && req_valid;
  assign busy      = run;
  assign frame_len = CNT_W'(hlen) + CNT_W'(2 * DATA_W);
  assign lsb_from  = CNT_W'(hlen) + CNT_W'(DATA_W + 1);
  assign in_hdr    = rise_cnt < CNT_W'(hlen);

  sconv_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half_len (half_q),
    .tick     (tick)
  );

  sconv_hdr #(.CNT_W(CNT_W)) u_hdr (
    .cfg   (cfg),
    .idx   (rise_cnt),
    .bit_o (hdr_bit),
    .len   (hlen)
  );

  sconv_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .sample   (run && tick && !sclk),
    .idx      (rise_cnt),
    .hlen     (hlen),
    .do_in    (do_in),
    .fwd_word (fwd_word),
    .rev_word (rev_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      half_q   <= '0;
      rise_cnt <= '0;
      run      <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      di_out   <= 1'b0;
      di_oe    <= 1'b0;
      lsb_en_n <= 1'b1;
      done     <= 1'b0;
      result   <= '0;
      mismatch <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cfg      <= '{chan: req_chan, diff: req_diff, wide: req_wide};
        half_q   <= req_half;
        rise_cnt <= '0;
        run      <= 1'b1;
        cs_n     <= 1'b0;
        sclk     <= 1'b0;
        di_out   <= 1'b1;
        di_oe    <= 1'b1;
        lsb_en_n <= 1'b1;
      end else if (run && tick) begin
        if (!sclk) begin
          sclk     <= 1'b1;
          rise_cnt <= rise_cnt + 1'b1;
        end else if (rise_cnt == frame_len) begin
          run      <= 1'b0;
          cs_n     <= 1'b1;
          sclk     <= 1'b0;
          di_out   <= 1'b0;
          di_oe    <= 1'b0;
          lsb_en_n <= 1'b1;
          done     <= 1'b1;
          result   <= fwd_word;
          mismatch <= (rev_word != fwd_word[DATA_W-1:1]);
        end else begin
          sclk     <= 1'b0;
          di_out   <= hdr_bit && in_hdr;
          di_oe    <= in_hdr;
          lsb_en_n <= !(rise_cnt >= lsb_from);
        end
      end
    end
  end
endmodule

// File: rtl/sconv_host_chk.sv
module sconv_host_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic di_out,
  input logic di_oe,
  input logic lsb_en_n,
  input logic done
);
  localparam int EDGE_LIM = 5 + 2 * DATA_W;
  localparam int EW       = $clog2(EDGE_LIM + 2);

  logic [EW-1:0] n_rise;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_rise <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)               n_rise <= '0;
      else if (sclk && !sclk_d) n_rise <= n_rise + 1'b1;
    end
  end

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!sclk && !di_oe && lsb_en_n));

  p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (di_oe && di_out && !sclk));

  p_di_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk) |=> (!sclk || $stable(di_out)));

  p_oe_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(di_oe) |-> ($fell(sclk) || $rose(cs_n)));

  p_lsb_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(lsb_en_n) |-> $fell(sclk));

  p_done_with_cs_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));

  p_cs_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_edge_limit_r9: assert property (@(posedge clk) disable iff (rst)
    n_rise <= EW'(EDGE_LIM));
endmodule

bind sconv_host sconv_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .di_out   (di_out),
  .di_oe    (di_oe),
  .lsb_en_n (lsb_en_n),
  .done     (done)
);

// File: tb/sim_sconv_host.sv
module sim_sconv_host;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic       req_diff = 1'b0;
  logic       req_wide = 1'b0;
  logic [7:0] req_half = '0;
  logic       do_in = 1'b0;
  logic       busy, cs_n, sclk, di_out, di_oe, lsb_en_n, done, mismatch;
  logic [7:0] result;

  always #2.5 clk = ~clk;

  sconv_host #(.DATA_W(8), .DIV_W(8)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_diff(req_diff), .req_wide(req_wide), .req_half(req_half),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .di_out(di_out), .di_oe(di_oe),
    .lsb_en_n(lsb_en_n), .do_in(do_in), .done(done), .result(result),
    .mismatch(mismatch)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state: t = cycles since chip select fell, -1 when idle
  int         t = -1;
  int         mL = 1, mN = 20, mH = 4;
  logic [4:0] mhdr = '0;
  logic [7:0] mcode = '0;
  bit         mbad = 1'b0;
  logic [7:0] f_code = '0;
  bit         f_bad = 1'b0;

  // converter model state
  int   rises = 0;
  logic sclk_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic advance();
    bit idle;
    idle = (t < 0) || (t == 2 * mN * mL);
    if (rst) t = -1;
    else if (idle) begin
      if (req_valid) begin
        t     = 0;
        mL    = (req_half == 0) ? 1 : int'(req_half);
        mH    = req_wide ? 5 : 4;
        mN    = mH + 16;
        mhdr  = req_wide ? {req_chan[1], req_chan[2], req_chan[0], ~req_diff, 1'b1}
                         : {1'b0, req_chan[1], req_chan[0], ~req_diff, 1'b1};
        mcode = f_code;
        mbad  = f_bad;
      end else t = -1;
    end else t++;
  endtask

  task automatic compare();
    int  k;
    bit  e_cs, e_sclk, e_oe, e_lsb, e_done, e_busy, e_di;
    e_di = 1'b0;
    if (t < 0 || t == 2 * mN * mL) begin
      e_cs = 1; e_sclk = 0; e_oe = 0; e_lsb = 1; e_busy = 0;
      e_done = (t >= 0);
    end else begin
      k      = t / (2 * mL);
      e_cs   = 0;
      e_sclk = ((t / mL) % 2) == 1;
      e_oe   = k < mH;
      e_di   = (k < mH) ? mhdr[k] : 1'b0;
      e_lsb  = !(k >= mH + 9);
      e_done = 0;
      e_busy = 1;
    end
    chk(cs_n == e_cs, "R9", "cs_n", 32'(cs_n), 32'(e_cs));
    chk(sclk == e_sclk, "R4", "sclk", 32'(sclk), 32'(e_sclk));
    chk(di_oe == e_oe, "R5", "di_oe", 32'(di_oe), 32'(e_oe));
    chk(lsb_en_n == e_lsb, "R7", "lsb_en_n", 32'(lsb_en_n), 32'(e_lsb));
    chk(done == e_done, "R9", "done", 32'(done), 32'(e_done));
    chk(busy == e_busy, "R10", "busy", 32'(busy), 32'(e_busy));
    if (e_oe) chk(di_out == e_di, "R3", "di_out", 32'(di_out), 32'(e_di));
    if (e_done) begin
      chk(result == mcode, "R6", "result", 32'(result), 32'(mcode));
      chk(mismatch == mbad, "R8", "mismatch", 32'(mismatch), 32'(mbad));
    end
  endtask

  // converter data, chosen from the number of rising edges seen so far
  task automatic drive_conv();
    int j;
    if (cs_n) rises = 0;
    else if (sclk && !sclk_seen) rises++;
    sclk_seen = sclk;
    if (rises == mH) do_in = 1'b1;                    // settle slot, must be dropped (R6)
    else if (rises >= mH + 1 && rises <= mH + 8) do_in = mcode[7 - (rises - mH - 1)];
    else if (rises >= mH + 9 && rises <= mH + 15) begin
      j     = rises - mH - 9;
      do_in = mcode[1 + j] ^ (mbad && j == 3);
    end else do_in = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    advance();
    @(negedge clk);
    cycles++;
    compare();
    drive_conv();
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most 20000", cycles);
      finish_run();
    end
  endtask

  task automatic frame(input bit wide, input logic [2:0] ch, input bit dif,
                       input logic [7:0] half, input logic [7:0] code,
                       input bit bad, input bit poke);
    int n;
    req_wide = wide; req_chan = ch; req_diff = dif; req_half = half;
    f_code = code; f_bad = bad;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    n = 0;
    while (t != 2 * mN * mL) begin
      if (poke && n == 7) begin
        // R10: request while busy must be ignored
        req_valid = 1'b1; req_chan = ~ch; req_diff = ~dif; req_wide = ~wide;
        f_code = ~code;
      end
      step();
      req_valid = 1'b0; req_chan = ch; req_diff = dif; req_wide = wide;
      n++;
    end
  endtask

  initial begin
    repeat (3) step();
    // R1: idle outputs under reset
    chk(cs_n && !sclk && !di_oe && lsb_en_n && !done && !busy, "R1", "reset idle",
        {26'd0, cs_n, sclk, di_oe, lsb_en_n, done, busy}, 32'h24);
    rst = 1'b0;
    step();
    frame(1'b0, 3'd2, 1'b0, 8'd1, 8'hA5, 1'b0, 1'b0);   // R2 R3 4-channel
    repeat (3) step();
    frame(1'b1, 3'd5, 1'b1, 8'd3, 8'h3C, 1'b0, 1'b0);   // R3 8-channel, R4 L=3
    frame(1'b1, 3'd6, 1'b0, 8'd0, 8'hFF, 1'b0, 1'b0);   // R11 back-to-back, R4 L=0
    repeat (2) step();
    frame(1'b0, 3'd3, 1'b1, 8'd2, 8'h00, 1'b1, 1'b0);   // R8 corrupt copy
    repeat (4) step();
    frame(1'b1, 3'd1, 1'b0, 8'd2, 8'h81, 1'b1, 1'b1);   // R10 mid-frame request
    frame(1'b0, 3'd0, 1'b0, 8'd4, 8'h5A, 1'b0, 1'b1);   // R10 R11
    repeat (5) step();
    finish_run();
  end
endmodule